// File: doc/BRIEF.md
# Debug Register Access Handler

This block sits at the edge of a debug module on a 16-bit packet interconnect. It collects one register request packet at a time, decides where the request belongs, and answers with a single response packet. The lower part of the register space is served locally by a handful of 16-bit base registers. These are read-only identification words set by parameters and a control word whose bit 0 is the module's active flag. That flag gates the module's event output. Requests to higher addresses are handed to the attached debug module through a held request/acknowledge port.

A request packet is a sequence of 16-bit flits, with `in_last` marking the final one. Flit 0 is the destination (ignored here). Flit 1 is the requester's address. Flit 2 is the header: bit 13 is 1 for a write and 0 for a read, and bits [1:0] are the width code (0 = 16, 1 = 32, 2 = 64, 3 = 128 bits). Flit 3 is the register address. A write then carries 2^code data flits, lowest word first. The response has three fixed flits: the requester's address, `MOD_ID`, and a header holding a kind code in bits [15:13] and the request's width code in bits [1:0]. The kind codes are 3'b010 for read done, 3'b011 for read failed, 3'b100 for write done and 3'b101 for write failed. A read that completes adds 2^code data flits, lowest word first.

The controller has four states. ST_RECV accepts flits and moves to ST_DECIDE on the last flit. ST_DECIDE moves to ST_FWD for a legal external access and otherwise to ST_SEND, applying a local write on the way. ST_FWD moves to ST_SEND on `ext_ack` or `ext_err`. ST_SEND returns to ST_RECV once the last response flit is taken.

Top module: `dbgreg_handler`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid`, `ext_req` and `mod_active` are 0, and a 16-bit read of address 3 returns 0.
- R2: Every response starts with the requester's address, then `MOD_ID`, then a header flit of {kind[2:0], 11'b0, width code[1:0]}.
- R3: 16-bit reads of addresses 0, 1, 2 and 4 return `VENDOR_ID`, `TYPE_ID`, `VERSION_ID` and `CAN_STALL` with the kind code read done and one data flit.
- R4: A 16-bit write to address 3 copies data bit 0 into `mod_active` and answers write done. A following read of address 3 returns {15'b0, active}.
- R5: Any local access (address below 0x200) with a width code other than 0 answers failed (3'b011 for a read, 3'b101 for a write), and a failed read carries no data flit.
- R6: A 16-bit access to an unimplemented local address (5 to 0x1FF) answers failed. So does a write to any of addresses 0, 1, 2 or 4.
- R7: An access to an address of 0x200 or above whose width is at most `MAX_REG_SIZE` raises `ext_req` with the request's address, width code, direction and write data (zero above the width). The handler completes on `ext_ack`. A read returns 2^code words of `ext_rdata`, lowest first.
- R8: An external access wider than `MAX_REG_SIZE` answers failed and never raises `ext_req`.
- R9: If `ext_err` is 1 during a forwarded access, the handler answers failed, even if `ext_ack` is also 1.
- R10: While `ext_req` is 1 and neither `ext_ack` nor `ext_err` is 1, the request stays up next cycle with address, width, direction and write data unchanged.
- R11: `in_ready` is 0 from the last request flit until the last response flit is taken. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold.
- R12: `evt_emit` equals `evt_req` while `mod_active` is 1 and is 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 16 | Request flit |
| in_valid | input | 1 | Request flit valid |
| in_last | input | 1 | Final flit of the request |
| in_ready | output | 1 | Handler accepts a request flit |
| out_data | output | 16 | Response flit |
| out_valid | output | 1 | Response flit valid |
| out_last | output | 1 | Final flit of the response |
| out_ready | input | 1 | Interconnect takes the response flit |
| ext_req | output | 1 | Forwarded access pending |
| ext_write | output | 1 | Forwarded access is a write |
| ext_addr | output | 16 | Forwarded register address |
| ext_width | output | 2 | Forwarded width code |
| ext_wdata | output | MAX_REG_SIZE | Forwarded write data |
| ext_rdata | input | MAX_REG_SIZE | Read data from the attached module |
| ext_ack | input | 1 | Attached module completed the access |
| ext_err | input | 1 | Attached module rejected the access |
| evt_req | input | 1 | Module wants to emit an event |
| evt_emit | output | 1 | Event emission after gating |
| mod_active | output | 1 | Active flag of the control word |

## Verification
The assertions check the following on every cycle: forwarded requests stay stable while the attached module has not answered, forwarded addresses are above the local range, forwarded widths fit `MAX_REG_SIZE`, a stalled response flit holds, no request flit is accepted while a response is pending, and events are only emitted while active. Only the bench's scenarios can show the decode results: which local addresses and widths fail, the contents of the identification words, the kind code and flit count of each response, that an oversized external access never reaches the port, and that the control write round-trips through a read.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

    typedef enum logic [1:0] {
        ST_RECV,
        ST_DECIDE,
        ST_FWD,
        ST_SEND
    } state_t;

    typedef enum logic [2:0] {
        K_NONE   = 3'b000,
        K_RD_OK  = 3'b010,
        K_RD_ERR = 3'b011,
        K_WR_OK  = 3'b100,
        K_WR_ERR = 3'b101
    } kind_t;

    localparam logic [15:0] EXT_BASE = 16'h0200;
    localparam int          WORD_W   = 16;
    localparam int          HDR_FLITS = 3;

    function automatic int unsigned width_bits(input logic [1:0] code);
        return 32'd16 << code;
    endfunction

endpackage

// File: rtl/dbgreg_base.sv
module dbgreg_base #(
    parameter logic [15:0] VENDOR_ID  = 16'h0001,
    parameter logic [15:0] TYPE_ID    = 16'h0002,
    parameter logic [15:0] VERSION_ID = 16'h0000,
    parameter bit          CAN_STALL  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] addr,
    input  logic        we,
    input  logic        wbit,
    output logic [15:0] rdata,
    output logic        rd_ok,
    output logic        wr_ok,
    output logic        active
);
    localparam logic [15:0] A_VENDOR  = 16'd0;
    localparam logic [15:0] A_TYPE    = 16'd1;
    localparam logic [15:0] A_VERSION = 16'd2;
    localparam logic [15:0] A_CTRL    = 16'd3;
    localparam logic [15:0] A_STALL   = 16'd4;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else if (we) begin
            active <= wbit;
        end
    end

    always_comb begin
        rdata = '0;
        rd_ok = 1'b1;
        wr_ok = (addr == A_CTRL);
        unique case (addr)
            A_VENDOR:  rdata = VENDOR_ID;
            A_TYPE:    rdata = TYPE_ID;
            A_VERSION: rdata = VERSION_ID;
            A_CTRL:    rdata = {15'b0, active};
            A_STALL:   rdata = {15'b0, CAN_STALL};
            default:   rd_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dbgreg_txmux.sv
module dbgreg_txmux #(
    parameter int          MAX_REG_SIZE = 64,
    parameter logic [15:0] MOD_ID       = 16'h0005
) (
    input  logic [3:0]              idx,
    input  logic [15:0]             dest,
    input  logic [15:0]             hdr,
    input  logic [MAX_REG_SIZE-1:0] rbuf,
    output logic [15:0]             flit
);
    localparam int NWORDS = MAX_REG_SIZE / 16;

    logic [15:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_split
        assign words[g] = rbuf[g*16 +: 16];
    end

    always_comb begin
        flit = '0;
        unique case (idx)
            4'd0:    flit = dest;
            4'd1:    flit = MOD_ID;
            4'd2:    flit = hdr;
            default: begin
                for (int k = 0; k < NWORDS; k++) begin
                    if (int'(idx) == k + 3) flit = words[k];
                end
            end
        endcase
    end
endmodule

// File: rtl/dbgreg_handler.sv
module dbgreg_handler
    import dbgreg_pkg::*;
#(
    parameter int          MAX_REG_SIZE = 64,
    parameter logic [15:0] MOD_ID       = 16'h0005,
    parameter logic [15:0] VENDOR_ID    = 16'h0001,
    parameter logic [15:0] TYPE_ID      = 16'h0002,
    parameter logic [15:0] VERSION_ID   = 16'h0000,
    parameter bit          CAN_STALL    = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [15:0]             in_data,
    input  logic                    in_valid,
    input  logic                    in_last,
    output logic                    in_ready,
    output logic [15:0]             out_data,
    output logic                    out_valid,
    output logic                    out_last,
    input  logic                    out_ready,
    output logic                    ext_req,
    output logic                    ext_write,
    output logic [15:0]             ext_addr,
    output logic [1:0]              ext_width,
    output logic [MAX_REG_SIZE-1:0] ext_wdata,
    input  logic [MAX_REG_SIZE-1:0] ext_rdata,
    input  logic                    ext_ack,
    input  logic                    ext_err,
    input  logic                    evt_req,
    output logic                    evt_emit,
    output logic                    mod_active
);
    localparam int NWORDS = MAX_REG_SIZE / WORD_W;
    localparam int CW     = 4;

    state_t                  state_q, state_d;
    logic [CW-1:0]           cnt_q, nflits_q;
    logic [15:0]             src_q, addr_q;
    logic                    wr_q;
    logic [1:0]              wcode_q;
    logic [MAX_REG_SIZE-1:0] wbuf_q, rbuf_q;
    kind_t                   kind_q;

    logic        is_ext, too_wide, fwd_ok, local_ok;
    logic [15:0] base_rdata;
    logic        base_rd_ok, base_wr_ok, base_we;
    logic [CW-1:0] widx;

    assign is_ext   = (addr_q >= EXT_BASE);
    assign too_wide = (width_bits(wcode_q) > MAX_REG_SIZE);
    assign fwd_ok   = is_ext && !too_wide;
    assign local_ok = !is_ext && (wcode_q == 2'd0) && (wr_q ? base_wr_ok : base_rd_ok);
    assign widx     = cnt_q - CW'(4);

    dbgreg_base #(
        .VENDOR_ID (VENDOR_ID),
        .TYPE_ID   (TYPE_ID),
        .VERSION_ID(VERSION_ID),
        .CAN_STALL (CAN_STALL)
    ) u_base (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr_q),
        .we    (base_we),
        .wbit  (wbuf_q[0]),
        .rdata (base_rdata),
        .rd_ok (base_rd_ok),
        .wr_ok (base_wr_ok),
        .active(mod_active)
    );

    dbgreg_txmux #(
        .MAX_REG_SIZE(MAX_REG_SIZE),
        .MOD_ID      (MOD_ID)
    ) u_txmux (
        .idx (cnt_q),
        .dest(src_q),
        .hdr ({kind_q, 11'b0, wcode_q}),
        .rbuf(rbuf_q),
        .flit(out_data)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECV:   if (in_valid && in_last) state_d = ST_DECIDE;
            ST_DECIDE: state_d = fwd_ok ? ST_FWD : ST_SEND;
            ST_FWD:    if (ext_ack || ext_err) state_d = ST_SEND;
            ST_SEND:   if (out_ready && out_last) state_d = ST_RECV;
            default:   state_d = ST_RECV;
        endcase
    end

    // state register and request/response fields
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RECV;
            cnt_q    <= '0;
            nflits_q <= CW'(HDR_FLITS);
            src_q    <= '0;
            addr_q   <= '0;
            wr_q     <= 1'b0;
            wcode_q  <= '0;
            wbuf_q   <= '0;
            rbuf_q   <= '0;
            kind_q   <= K_NONE;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_RECV: if (in_valid) begin
                    if (in_last)             cnt_q <= '0;
                    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
                    unique case (cnt_q)
                        4'd0:    wbuf_q <= '0;
                        4'd1:    src_q  <= in_data;
                        4'd2:    begin
                            wr_q    <= in_data[13];
                            wcode_q <= in_data[1:0];
                        end
                        4'd3:    addr_q <= in_data;
                        default: begin
                            for (int k = 0; k < NWORDS; k++) begin
                                if (int'(widx) == k) wbuf_q[k*16 +: 16] <= in_data;
                            end
                        end
                    endcase
                end
                ST_DECIDE: if (!fwd_ok) begin
                    rbuf_q   <= MAX_REG_SIZE'(base_rdata);
                    kind_q   <= wr_q ? (local_ok ? K_WR_OK : K_WR_ERR)
                                     : (local_ok ? K_RD_OK : K_RD_ERR);
                    nflits_q <= (!wr_q && local_ok) ? CW'(HDR_FLITS + 1) : CW'(HDR_FLITS);
                end
                ST_FWD: begin
                    if (ext_err) begin
                        kind_q   <= wr_q ? K_WR_ERR : K_RD_ERR;
                        nflits_q <= CW'(HDR_FLITS);
                    end else if (ext_ack) begin
                        kind_q   <= wr_q ? K_WR_OK : K_RD_OK;
                        rbuf_q   <= ext_rdata;
                        nflits_q <= wr_q ? CW'(HDR_FLITS)
                                         : CW'(HDR_FLITS) + (CW'(1) << wcode_q);
                    end
                end
                ST_SEND: if (out_ready) begin
                    cnt_q <= out_last ? '0 : cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = (state_q == ST_RECV);
        out_valid = (state_q == ST_SEND);
        out_last  = (state_q == ST_SEND) && (cnt_q == nflits_q - 1'b1);
        ext_req   = (state_q == ST_FWD);
        ext_write = wr_q;
        ext_addr  = addr_q;
        ext_width = wcode_q;
        ext_wdata = wbuf_q;
        base_we   = (state_q == ST_DECIDE) && !is_ext && wr_q
                    && (wcode_q == 2'd0) && base_wr_ok;
        evt_emit  = evt_req && mod_active;
    end
endmodule

// File: rtl/dbgreg_handler_chk.sv
module dbgreg_handler_chk #(
    parameter int MAX_REG_SIZE = 64
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_ready,
    input logic [15:0]             out_data,
    input logic                    out_valid,
    input logic                    out_last,
    input logic                    out_ready,
    input logic                    ext_req,
    input logic                    ext_write,
    input logic [15:0]             ext_addr,
    input logic [1:0]              ext_width,
    input logic [MAX_REG_SIZE-1:0] ext_wdata,
    input logic                    ext_ack,
    input logic                    ext_err,
    input logic                    evt_emit,
    input logic                    mod_active
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        ext_req && !ext_ack && !ext_err |=> ext_req && $stable(ext_addr)
        && $stable(ext_width) && $stable(ext_write) && $stable(ext_wdata)); // R10

    AST_FWD_HIGH_ONLY: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> ext_addr >= 16'h0200); // R7

    AST_FWD_WIDTH_FITS: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> (32'd16 << ext_width) <= MAX_REG_SIZE); // R8

    AST_SEND_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R11

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (out_valid || ext_req) |-> !in_ready); // R11

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
        evt_emit |-> mod_active); // R12
endmodule

bind dbgreg_handler dbgreg_handler_chk #(.MAX_REG_SIZE(MAX_REG_SIZE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready),
    .ext_req   (ext_req),
    .ext_write (ext_write),
    .ext_addr  (ext_addr),
    .ext_width (ext_width),
    .ext_wdata (ext_wdata),
    .ext_ack   (ext_ack),
    .ext_err   (ext_err),
    .evt_emit  (evt_emit),
    .mod_active(mod_active)
);

// File: tb/dbgreg_handler_test.sv
module dbgreg_handler_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          MAXR       = 64;
    localparam logic [15:0] MYID       = 16'h0005;
    localparam logic [15:0] VEND       = 16'h0001;
    localparam logic [15:0] TYP        = 16'h0002;
    localparam logic [15:0] VER        = 16'h0000;
    localparam bit          STALL      = 1'b1;

    logic clk = 0, rst = 1;
    logic [15:0] in_data = 0;
    logic in_valid = 0, in_last = 0, in_ready;
    logic [15:0] out_data;
    logic out_valid, out_last, out_ready = 0;
    logic ext_req, ext_write;
    logic [15:0] ext_addr;
    logic [1:0] ext_width;
    logic [MAXR-1:0] ext_wdata, ext_rdata = 0;
    logic ext_ack = 0, ext_err = 0;
    logic evt_req = 0, evt_emit, mod_active;

    int tests = 0, fails = 0;
    bit done = 0;
    bit err_mode = 0;
    bit act_model = 0;
    int ext_seen = 0;
    logic [15:0] cap_addr;
    logic [MAXR-1:0] cap_wdata;
    logic cap_write;
    logic [1:0] cap_width;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbgreg_handler #(.MAX_REG_SIZE(MAXR), .MOD_ID(MYID), .VENDOR_ID(VEND),
        .TYPE_ID(TYP), .VERSION_ID(VER), .CAN_STALL(STALL)) uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
        .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .ext_req(ext_req), .ext_write(ext_write), .ext_addr(ext_addr),
        .ext_width(ext_width), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
        .ext_ack(ext_ack), .ext_err(ext_err), .evt_req(evt_req),
        .evt_emit(evt_emit), .mod_active(mod_active));

    function automatic logic [63:0] pat(input logic [15:0] a);
        return {a ^ 16'h4444, a ^ 16'h3333, a ^ 16'h2222, a ^ 16'h1111};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model of the attached debug module
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (ext_ack || ext_err) begin
                ext_ack = 0; ext_err = 0;
            end else if (ext_req) begin
                if (dly == 0) begin
                    ext_seen++;
                    cap_addr = ext_addr; cap_wdata = ext_wdata;
                    cap_write = ext_write; cap_width = ext_width;
                    ext_rdata = pat(ext_addr);
                    if (err_mode) ext_err = 1; else ext_ack = 1;
                    dly = $urandom % 4;
                end else dly--;
            end
        end
    end

    task automatic send_flit(input logic [15:0] d, input bit last);
        @(negedge clk);
        in_valid = 1; in_data = d; in_last = last;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic txn(input bit wr, input logic [1:0] wc,
                       input logic [15:0] a, input logic [127:0] d);
        logic [15:0] src;
        logic [2:0] kind;
        logic [15:0] rsp [16];
        logic [15:0] exp_words [8];
        int nexp, nwords, n, seen0, bits;
        bit ext_path, prev_stall;
        logic [15:0] prev_data;
        string tag;
        logic [63:0] mask;
        src = 16'($urandom);
        bits = 16 << wc;
        ext_path = 0; nwords = 0;
        for (int i = 0; i < 8; i++) exp_words[i] = 0;
        if (a >= 16'h0200) begin
            if (bits > MAXR) begin tag = "R8"; kind = wr ? 3'b101 : 3'b011; end
            else if (err_mode) begin tag = "R9"; kind = wr ? 3'b101 : 3'b011; ext_path = 1; end
            else begin
                tag = "R7"; kind = wr ? 3'b100 : 3'b010; ext_path = 1;
                if (!wr) begin
                    nwords = 1 << wc;
                    for (int i = 0; i < nwords; i++) exp_words[i] = pat(a)[i*16 +: 16];
                end
            end
        end else if (wc != 0) begin
            tag = "R5"; kind = wr ? 3'b101 : 3'b011;
        end else if (wr) begin
            if (a == 16'd3) begin tag = "R4"; kind = 3'b100; act_model = d[0]; end
            else begin tag = "R6"; kind = 3'b101; end
        end else begin
            if (a <= 16'd4) begin
                tag = (a == 16'd3) ? "R4" : "R3"; kind = 3'b010; nwords = 1;
                case (a)
                    16'd0: exp_words[0] = VEND;
                    16'd1: exp_words[0] = TYP;
                    16'd2: exp_words[0] = VER;
                    16'd3: exp_words[0] = {15'b0, act_model};
                    default: exp_words[0] = {15'b0, STALL};
                endcase
            end else begin tag = "R6"; kind = 3'b011; end
        end
        nexp = 3 + nwords;
        seen0 = ext_seen;

        send_flit(MYID, 0);
        send_flit(src, 0);
        send_flit({2'b00, wr, 11'b0, wc}, 0);
        send_flit(a, !wr);
        if (wr) for (int i = 0; i < (1 << wc); i++) send_flit(d[i*16 +: 16], i == (1 << wc) - 1);
        @(negedge clk);
        in_valid = 0; in_last = 0;
        #1 chk(in_ready == 0, "R11 busy", in_ready, 0);

        n = 0; prev_stall = 0; prev_data = 0;
        for (int it = 0; it < 200 && n < 16; it++) begin
            @(negedge clk);
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R11 hold", out_data, prev_data);
            out_ready = ($urandom % 4) != 0;
            #1;
            if (out_valid && in_ready) chk(0, "R11 ready", in_ready, 0);
            prev_stall = out_valid && !out_ready;
            prev_data = out_data;
            if (out_valid && out_ready) begin
                rsp[n] = out_data; n++;
                if (out_last) break;
            end
        end
        @(negedge clk); out_ready = 0;

        chk(n == nexp, {tag, " flit count"}, n, nexp);
        chk(rsp[0] == src && rsp[1] == MYID, "R2 addresses", {rsp[0], rsp[1]}, {src, MYID});
        chk(rsp[2] == {kind, 11'b0, wc}, {tag, " header"}, rsp[2], {kind, 11'b0, wc});
        for (int i = 0; i < nwords && i + 3 < n; i++)
            chk(rsp[i+3] == exp_words[i], {tag, " data"}, rsp[i+3], exp_words[i]);
        if (ext_path) begin
            mask = (bits >= 64) ? '1 : ((64'd1 << bits) - 1);
            chk(ext_seen == seen0 + 1 && cap_addr == a && cap_write == wr && cap_width == wc,
                "R7 request", {cap_addr, cap_width}, {a, wc});
            if (wr) chk(cap_wdata == (d[63:0] & mask), "R7 wdata", cap_wdata, d[63:0] & mask);
        end else begin
            chk(ext_seen == seen0, {tag, " no forward"}, ext_seen, seen0);
        end
        chk(mod_active == act_model, "R4 active", mod_active, act_model);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk(in_ready && !out_valid && !ext_req && !mod_active, "R1 reset",
            {in_ready, out_valid, ext_req, mod_active}, 4'b1000);
        txn(0, 0, 16'd3, 0);                  // R1 control reads 0
        for (int a = 0; a <= 4; a++) txn(0, 0, 16'(a), 0); // R3
        evt_req = 1;
        @(negedge clk); #1 chk(evt_emit == 0, "R12 gated", evt_emit, 0);
        txn(1, 0, 16'd3, 128'h1);             // R4
        txn(0, 0, 16'd3, 0);
        @(negedge clk); #1 chk(evt_emit == 1, "R12 pass", evt_emit, 1);
        txn(0, 1, 16'd0, 0);                  // R5
        txn(1, 2, 16'd3, 128'h0);             // R5: width error leaves active
        txn(0, 0, 16'h0100, 0);               // R6
        txn(1, 0, 16'h0100, 128'hdead);
        txn(1, 0, 16'd0, 128'h7);             // R6 read-only
        txn(1, 2, 16'h0200, 128'h1122334455667788);   // R7
        txn(0, 1, 16'hFFFF, 0);
        txn(1, 3, 16'h0300, {4{32'hCAFEF00D}});       // R8
        txn(0, 3, 16'h0400, 0);
        err_mode = 1;
        txn(1, 0, 16'h0500, 128'h55);         // R9
        txn(0, 2, 16'h0600, 0);
        err_mode = 0;
        txn(1, 0, 16'd3, 128'h0);
        @(negedge clk); #1 chk(evt_emit == 0, "R12 regated", evt_emit, 0);
        for (int it = 0; it < 60; it++) begin
            int cat;
            logic [15:0] a;
            cat = $urandom % 6;
            case (cat)
                0: a = 16'($urandom % 5);
                1: a = 16'd3;
                2: a = 16'(5 + $urandom % 16'h01FB);
                default: a = 16'(16'h0200 + $urandom % 16'hFE00);
            endcase
            err_mode = (cat >= 3) && ($urandom % 5 == 0);
            txn(1'($urandom), 2'($urandom), a,
                {$urandom, $urandom, $urandom, $urandom});
            @(negedge clk); #1 chk(evt_emit == (evt_req && act_model), "R12 random",
                                   evt_emit, act_model);
        end
        err_mode = 0;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule